// File: doc/BRIEF.md
# Double-Buffered Output Compare Channel

This block is one compare channel of a 16-bit timer that sits on an 8-bit processor bus. It keeps a 16-bit compare word and checks it against the running counter value on every clock. While the two are equal it drives a hit signal toward the waveform logic, and it latches a sticky interrupt request flag. The counter and the pin waveform logic are outside the block.

Software cannot load 16 bits at once, so it loads the word as two bytes. The high byte goes to a shared staging register first. The low-byte write then commits both bytes in a single clock. In the PWM modes, a hold buffer keeps the committed word back until the counter signals TOP or BOTTOM, whichever the update-point select chooses. This keeps a pulse from being cut short when software changes the word part-way through a period. In the non-PWM modes, the low-byte write loads the active compare word directly.

Top module: `ocmp_channel`

## Requirements
- R1: While reset is low, the active compare word, hold buffer, staging byte and interrupt flag are all zero, and every read address returns 0.
- R2: A write to bus address 1 (high byte) only stores the byte in the staging register. Neither the active compare word nor the value read back at addresses 0 and 1 changes.
- R3: With `buf_mode` low, a write to bus address 0 loads {staging byte, written byte} into the active compare word at that clock edge.
- R4: With `buf_mode` high, a write to address 0 loads {staging byte, written byte} into the hold buffer only. The active compare word keeps its old value.
- R5: With `buf_mode` high and `upd_sel[0]` set, an `at_top` strobe copies the hold buffer into the active compare word at that edge.
- R6: With `buf_mode` high and `upd_sel[1]` set, an `at_bottom` strobe copies the buffer. A strobe whose select bit is clear has no effect.
- R7: `cmp_hit` is high in exactly those cycles where `cnt_val` equals the active compare word.
- R8: A clock edge at which `cmp_hit` is high sets `irq_flag`, and the flag stays set until it is cleared.
- R9: Writing data bit 0 = 1 to address 2, or raising `irq_ack`, clears the flag. Writing 0 to address 2 leaves the flag unchanged.
- R10: When a clear and a hit fall at the same edge, the flag ends set.
- R11: When a low-byte write into the buffer and a transfer fall at the same edge, the active word takes the old buffer value and the buffer takes the new word.
- R12: Reads are combinational and never pass through the staging register. Address 0 returns the low byte and address 1 the high byte of the hold buffer when `buf_mode` is high, or of the active word when it is low. Address 2 returns the flag in bit 0, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 16 | Running counter value |
| at_top | input | 1 | Counter is at TOP this cycle |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| buf_mode | input | 1 | High in PWM modes: buffered update |
| upd_sel | input | 2 | Transfer point: bit 0 TOP, bit 1 BOTTOM |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 flag, 3 unused |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq_flag | output | 1 | Sticky compare interrupt request |
| cmp_hit | output | 1 | Counter equals active compare word |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a buffered low-byte write and a TOP/BOTTOM transfer. The bench drives the write strobe and the selected strobe in the same cycle. It expects a hit at the old buffered word and a readback of the new one. The second pair is a flag clear and a fresh hit. The bench holds the counter on the compare word while pulsing the acknowledge input, and it expects the flag to stay set.

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*BW-1:0] cnt_val,
  input  logic          at_top,
  input  logic          at_bottom,
  input  logic          buf_mode,
  input  logic [1:0]    upd_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          irq_ack,
  output logic          irq_flag,
  output logic          cmp_hit
);
  localparam int CW = 2 * BW;

  logic [BW-1:0] stage_q;
  logic [CW-1:0] hold_q;
  logic [CW-1:0] cmp_q;
  logic          flag_q;

  logic wr_lo, wr_hi, wr_flag, xfer, clr;
  logic [CW-1:0] new_word, view;

  assign wr_lo    = bus_wr && (bus_addr == 2'd0);
  assign wr_hi    = bus_wr && (bus_addr == 2'd1);
  assign wr_flag  = bus_wr && (bus_addr == 2'd2);
  assign new_word = {stage_q, bus_wdata};
  assign xfer     = buf_mode && ((at_top && upd_sel[0]) || (at_bottom && upd_sel[1]));
  assign clr      = irq_ack || (wr_flag && bus_wdata[0]);
  assign view     = buf_mode ? hold_q : cmp_q;
  assign cmp_hit  = (cnt_val == cmp_q);
  assign irq_flag = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else if (wr_hi) stage_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (wr_lo && buf_mode) hold_q <= new_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_q <= '0;
    else if (wr_lo && !buf_mode) cmp_q <= new_word;
    else if (xfer) cmp_q <= hold_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (cmp_hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = view[BW-1:0];
      2'd1:    bus_rdata = view[CW-1:BW];
      2'd2:    bus_rdata = {{(BW-1){1'b0}}, flag_q};
      default: bus_rdata = '0;
    endcase
  end

  a_r2_hi_write_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !xfer) |=> ($stable(cmp_q) && $stable(hold_q)));

  a_r3_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !buf_mode) |=> (cmp_q == $past(new_word)));

  a_r4_buffered_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !xfer) |=> $stable(cmp_q));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> flag_q);

  a_r11_xfer_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wr_lo) |=> (cmp_q == $past(hold_q)));
endmodule

// File: tb/sim_ocmp_channel.sv
`timescale 1ns/1ps
module sim_ocmp_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cnt_val = 16'hFFFF;
  logic at_top = 1'b0, at_bottom = 1'b0, buf_mode = 1'b0;
  logic [1:0] upd_sel = 2'b01;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq_ack = 1'b0;
  logic irq_flag, cmp_hit;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ocmp_channel u0 (.clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .at_top(at_top),
    .at_bottom(at_bottom), .buf_mode(buf_mode), .upd_sel(upd_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq_flag(irq_flag), .cmp_hit(cmp_hit));

  // {compare word, counter value, expected hit}
  localparam logic [32:0] VEC [6] = '{
    {16'h1234, 16'h1234, 1'b1}, {16'h1234, 16'h1235, 1'b0},
    {16'hABCD, 16'hABCD, 1'b1}, {16'h00FF, 16'hFF00, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b1}, {16'h8000, 16'h0080, 1'b0}};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic set_cnt(input logic [15:0] v);
    @(negedge clk); cnt_val = v; #1;
  endtask

  task automatic check_view(input string tag, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    chk(tag, {hi, lo}, exp);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1 flag", {15'd0, irq_flag}, 16'd0);
    check_view("R1 word", 16'h0000);
    rd(2'd2, d); chk("R1 flag read", {8'd0, d}, 16'd0);
    chk("R1 hit", {15'd0, cmp_hit}, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3/R7 table of direct loads
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, VEC[i][32:25]);
      wr(2'd0, VEC[i][24:17]);
      set_cnt(VEC[i][16:1]);
      chk("R7 table hit", {15'd0, cmp_hit}, {15'd0, VEC[i][0]});
      check_view("R3 table readback", VEC[i][32:17]);
    end

    // R9 clears
    set_cnt(16'h0001);
    wr(2'd2, 8'h01);
    chk("R9 write-one clear", {15'd0, irq_flag}, 16'd0);
    set_cnt(16'h8000); set_cnt(16'h0001);
    chk("R8 flag set by hit", {15'd0, irq_flag}, 16'd1);
    repeat (3) @(negedge clk); #1;
    chk("R8 flag sticky", {15'd0, irq_flag}, 16'd1);
    wr(2'd2, 8'h00);
    chk("R9 write-zero ignored", {15'd0, irq_flag}, 16'd1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0; #1;
    chk("R9 ack clear", {15'd0, irq_flag}, 16'd0);

    // R10 clear and hit same edge
    @(negedge clk); cnt_val = 16'h8000; irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0; cnt_val = 16'h0001; #1;
    chk("R10 set wins", {15'd0, irq_flag}, 16'd1);

    // R2 high write hidden
    wr(2'd1, 8'h55);
    check_view("R2 readback after high write", 16'h8000);
    set_cnt(16'h8000);
    chk("R2 word unchanged", {15'd0, cmp_hit}, 16'd1);
    wr(2'd0, 8'h66);
    set_cnt(16'h5566);
    chk("R3 staged byte used", {15'd0, cmp_hit}, 16'd1);

    // R4 buffered write
    buf_mode = 1'b1; upd_sel = 2'b01;
    wr(2'd1, 8'h12); wr(2'd0, 8'h34);
    check_view("R4 buffer readback", 16'h1234);
    set_cnt(16'h5566);
    chk("R4 active word kept", {15'd0, cmp_hit}, 16'd1);

    // R6 unselected strobe ignored, R5 top transfer
    @(negedge clk); at_bottom = 1'b1; @(negedge clk); at_bottom = 1'b0;
    set_cnt(16'h1234);
    chk("R6 unselected bottom ignored", {15'd0, cmp_hit}, 16'd0);
    @(negedge clk); at_top = 1'b1; @(negedge clk); at_top = 1'b0; #1;
    chk("R5 top transfer", {15'd0, cmp_hit}, 16'd1);

    // R6 bottom transfer
    upd_sel = 2'b10;
    wr(2'd1, 8'h0A); wr(2'd0, 8'h0B);
    @(negedge clk); at_top = 1'b1; @(negedge clk); at_top = 1'b0;
    set_cnt(16'h0A0B);
    chk("R6 unselected top ignored", {15'd0, cmp_hit}, 16'd0);
    @(negedge clk); at_bottom = 1'b1; @(negedge clk); at_bottom = 1'b0; #1;
    chk("R6 bottom transfer", {15'd0, cmp_hit}, 16'd1);

    // R11 write and transfer in the same cycle
    wr(2'd1, 8'h0C); wr(2'd0, 8'h0D);
    wr(2'd1, 8'h0E);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h0F; at_bottom = 1'b1;
    @(negedge clk); bus_wr = 1'b0; at_bottom = 1'b0;
    set_cnt(16'h0C0D);
    chk("R11 active takes old buffer", {15'd0, cmp_hit}, 16'd1);
    check_view("R11 buffer takes new word", 16'h0E0F);
    @(negedge clk); at_bottom = 1'b1; @(negedge clk); at_bottom = 1'b0;
    set_cnt(16'h0E0F);
    chk("R11 later transfer", {15'd0, cmp_hit}, 16'd1);

    // R12 read mux
    wr(2'd1, 8'h77); wr(2'd0, 8'h88);
    check_view("R12 buffered view", 16'h7788);
    buf_mode = 1'b0;
    check_view("R12 direct view", 16'h0E0F);
    rd(2'd3, d); chk("R12 unused address", {8'd0, d}, 16'd0);
    rd(2'd2, d); chk("R12 flag address", {8'd0, d}, 16'd1);

    finish_run();
  end
endmodule